// File: doc/BRIEF.md
# Machine State Register Update Unit

This block keeps the 64-bit machine state register of a processor execute stage and applies every architected change to it: the reset value, the changes made on interrupt entry, return from interrupt, the two forms of the move-to-register operation, and read-back through the move-from-register operation. In the same cycle it flags any instruction that needs privilege and is issued while the problem-state bit is set.

The execute stage presents one operation per cycle on `op_sel`, along with the source operand, the L field and the instruction word. It raises `irq_take` when an interrupt is accepted. The register value is always visible on `msr`. `rd_data` carries the read-back result. `priv_fault` tells the stage to raise a privileged-type program interrupt in place of the operation. Bit numbering is little-endian (bit 0 is the LSB). The positions are: SF 63, HV 60, EE 15, PR 14, ME 12, IR 5, DR 4, RI 1, LE 0.

Top module: `msr_update_unit`

## Requirements
- R1: After a synchronous active-low reset, `msr` equals 64'h8000_0000_0000_0001 (SF and LE set, every other bit clear).
- R2: A clock edge with `irq_take`=1 sets SF and LE, clears PR, IR, DR and RI, and leaves every other bit unchanged.
- R3: `irq_take` takes priority over any operation presented in the same cycle. That operation has no effect on `msr`.
- R4: Move-to-register (`op_sel`=2) with `l_field`=1 copies only EE and RI from `operand`.
- R5: Move-to-register with `l_field`=0 copies `operand` into every bit except HV, ME and LE, which keep their values.
- R6: Return from interrupt (`op_sel`=1) copies SF, HV, EE, PR, ME, IR, DR, RI and LE from `operand`. All other bits keep their values.
- R7: When a move-to-register or return-from-interrupt leaves PR=1, EE, IR and DR are also set to 1.
- R8: When the operation is move-from-register (`op_sel`=3) and it is not faulting, `rd_data` equals the full `msr`. In every other case `rd_data` is 0.
- R9: When PR=1, `priv_fault` is 1 for the following operations: `op_sel` 1, 2 or 3; `op_sel`=5 (other privileged instruction); and `op_sel`=4 (special-register move) only when `insn[20]`=1. A faulting operation leaves `msr` unchanged. Codes 0, 6 and 7 never fault and never change `msr`.
- R10: When PR=0, `priv_fault` stays 0 for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code (see R4 to R9) |
| operand | input | 64 | Source value for move-to-register and return from interrupt |
| l_field | input | 1 | Selects the two-bit form of move-to-register |
| insn | input | 32 | Instruction word; bit 20 marks a privileged special register |
| irq_take | input | 1 | Interrupt entry strobe |
| msr | output | 64 | Current register value |
| rd_data | output | 64 | Read-back result |
| priv_fault | output | 1 | Privileged-instruction violation |

## Verification
An all-ones operand is used to tell which bits each update form protects, and an all-zero operand to tell which bits it clears. Return from interrupt is exercised after the partial-function bits have been zeroed, with an all-ones operand and with a PR-only operand. The first case separates copied fields from kept ones. The second shows the EE/IR/DR forcing. Special-register moves are presented with instruction bit 20 clear and set, which separates the two privilege classes. An interrupt strobe is raised together with a faulting move, which shows that interrupt entry wins.

// File: rtl/msr_update_unit.sv
module msr_update_unit #(
  parameter int XLEN = 64,
  parameter int SPR_PRIV_BIT = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_sel,
  input  logic [XLEN-1:0] operand,
  input  logic            l_field,
  input  logic [31:0]     insn,
  input  logic            irq_take,
  output logic [XLEN-1:0] msr,
  output logic [XLEN-1:0] rd_data,
  output logic            priv_fault
);

  localparam int P_SF = 63, P_HV = 60, P_EE = 15, P_PR = 14;
  localparam int P_ME = 12, P_IR = 5, P_DR = 4, P_RI = 1, P_LE = 0;

  localparam logic [XLEN-1:0] ONE    = XLEN'(1);
  localparam logic [XLEN-1:0] M_SF   = ONE << P_SF;
  localparam logic [XLEN-1:0] M_HV   = ONE << P_HV;
  localparam logic [XLEN-1:0] M_EE   = ONE << P_EE;
  localparam logic [XLEN-1:0] M_PR   = ONE << P_PR;
  localparam logic [XLEN-1:0] M_ME   = ONE << P_ME;
  localparam logic [XLEN-1:0] M_IR   = ONE << P_IR;
  localparam logic [XLEN-1:0] M_DR   = ONE << P_DR;
  localparam logic [XLEN-1:0] M_RI   = ONE << P_RI;
  localparam logic [XLEN-1:0] M_LE   = ONE << P_LE;

  localparam logic [XLEN-1:0] RST_VAL   = M_SF | M_LE;
  localparam logic [XLEN-1:0] IRQ_CLR   = M_PR | M_IR | M_DR | M_RI;
  localparam logic [XLEN-1:0] RET_MASK  = M_SF | M_HV | M_EE | M_PR | M_ME | M_IR | M_DR | M_RI | M_LE;
  localparam logic [XLEN-1:0] SHORT_MSK = M_EE | M_RI;
  localparam logic [XLEN-1:0] FULL_KEEP = M_HV | M_ME | M_LE;
  localparam logic [XLEN-1:0] PR_FORCE  = M_EE | M_IR | M_DR;

  localparam logic [2:0] OP_RET = 3'd1, OP_MTM = 3'd2, OP_MFM = 3'd3;
  localparam logic [2:0] OP_SPR = 3'd4, OP_PRV = 3'd5;

  logic            needs_priv;
  logic            is_write;
  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] next_val;

  assign needs_priv = (op_sel == OP_RET) || (op_sel == OP_MTM) || (op_sel == OP_MFM) ||
                      (op_sel == OP_PRV) || (op_sel == OP_SPR && insn[SPR_PRIV_BIT]);
  assign priv_fault = msr[P_PR] & needs_priv;
  assign is_write   = (op_sel == OP_RET) || (op_sel == OP_MTM);
  assign rd_data    = (op_sel == OP_MFM && !priv_fault) ? msr : '0;

  always_comb begin
    if (op_sel == OP_RET)
      merged = (msr & ~RET_MASK) | (operand & RET_MASK);
    else if (l_field)
      merged = (msr & ~SHORT_MSK) | (operand & SHORT_MSK);
    else
      merged = (operand & ~FULL_KEEP) | (msr & FULL_KEEP);
    next_val = merged[P_PR] ? (merged | PR_FORCE) : merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      msr <= RST_VAL;
    else if (irq_take)
      msr <= (msr | M_SF | M_LE) & ~IRQ_CLR;
    else if (is_write && !priv_fault)
      msr <= next_val;
  end

  p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> msr == RST_VAL);

  p_irq_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> msr[P_SF] && msr[P_LE] && !msr[P_PR] && !msr[P_IR] && !msr[P_DR] && !msr[P_RI]);

  p_irq_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (msr & ~(RST_VAL | IRQ_CLR)) == ($past(msr) & ~(RST_VAL | IRQ_CLR)));

  p_short_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_MTM && l_field && !irq_take && !priv_fault) |=>
      (msr & ~SHORT_MSK) == ($past(msr) & ~SHORT_MSK));

  p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_MTM && !l_field && !irq_take) |=>
      (msr & FULL_KEEP) == ($past(msr) & FULL_KEEP));

  p_pr_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msr[P_PR] |-> msr[P_EE] && msr[P_IR] && msr[P_DR]);

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_fault && !irq_take) |=> $stable(msr));

  p_no_fault_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !msr[P_PR] |-> !priv_fault);

endmodule

// File: tb/msr_update_unit_bench.sv
module msr_update_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  op_sel = 0;
  logic [63:0] operand = 0;
  logic        l_field = 0;
  logic [31:0] insn = 0;
  logic        irq_take = 0;
  logic [63:0] msr, rd_data;
  logic        priv_fault;

  int checks = 0;
  int failures = 0;
  logic [63:0] model;

  always #2 clk = ~clk;

  msr_update_unit u_msr_update_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand), .l_field(l_field),
    .insn(insn), .irq_take(irq_take), .msr(msr), .rd_data(rd_data), .priv_fault(priv_fault));

  // {op[2:0], l, irq, insn20, 2'b0, operand[63:0]}
  localparam logic [71:0] VEC [15] = '{
    {3'd2, 1'b0, 1'b0, 1'b0, 2'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd3, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd4, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd4, 1'b0, 1'b0, 1'b1, 2'b0, 64'h0},
    {3'd5, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd0, 1'b0, 1'b1, 1'b0, 2'b0, 64'h0},
    {3'd3, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd2, 1'b1, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd2, 1'b1, 1'b0, 1'b0, 2'b0, 64'h0000_0000_0000_8002},
    {3'd1, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0000_0000_0000_4000},
    {3'd2, 1'b0, 1'b1, 1'b0, 2'b0, 64'h0},
    {3'd2, 1'b0, 1'b0, 1'b0, 2'b0, 64'h0},
    {3'd1, 1'b0, 1'b0, 1'b0, 2'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd6, 1'b0, 1'b0, 1'b1, 2'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd0, 1'b0, 1'b1, 1'b0, 2'b0, 64'h0}
  };

  function automatic logic exp_fault(logic [63:0] cur, logic [2:0] op, logic s20);
    logic p;
    p = (op == 3'd1) || (op == 3'd2) || (op == 3'd3) || (op == 3'd5) || (op == 3'd4 && s20);
    return cur[14] && p;
  endfunction

  function automatic logic [63:0] exp_next(logic [63:0] cur, logic [2:0] op, logic l,
                                           logic irq, logic s20);
    logic [63:0] r;
    r = cur;
    if (irq) begin
      r[63] = 1; r[0] = 1; r[14] = 0; r[5] = 0; r[4] = 0; r[1] = 0;
      return r;
    end
    if (exp_fault(cur, op, s20)) return cur;
    if (op == 3'd2 && l) begin
      r[15] = operand[15]; r[1] = operand[1];
    end else if (op == 3'd2) begin
      r = operand; r[60] = cur[60]; r[12] = cur[12]; r[0] = cur[0];
    end else if (op == 3'd1) begin
      foreach (r[i]) if (i inside {63, 60, 15, 14, 12, 5, 4, 1, 0}) r[i] = operand[i];
    end else return cur;
    if (r[14]) begin r[15] = 1; r[5] = 1; r[4] = 1; end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic l, logic irq);
    if (irq) return (op != 0) ? "R3" : "R2";
    if (op == 3'd2) return l ? "R4/R7" : "R5/R7";
    if (op == 3'd1) return "R6/R7";
    return "R9";
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 0; op_sel = 0; irq_take = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model = 64'h8000_0000_0000_0001;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    apply_reset();
    #1;
    check64("R1", msr, 64'h8000_0000_0000_0001);
    check64("R10", {63'd0, priv_fault}, 64'd0);
    check64("R8", rd_data, 64'd0);

    for (int i = 0; i < 15; i++) begin
      logic [2:0] op; logic l, irq, s20; logic ef; string t;
      {op, l, irq, s20} = VEC[i][71:66];
      @(negedge clk);
      op_sel = op; l_field = l; irq_take = irq; insn = {11'd0, s20, 20'd0};
      operand = VEC[i][63:0];
      #1;
      ef = exp_fault(model, op, s20);
      check64(model[14] ? "R9" : "R10", {63'd0, priv_fault}, {63'd0, ef});
      check64("R8", rd_data, (op == 3'd3 && !ef) ? model : 64'd0);
      model = exp_next(model, op, l, irq, s20);
      t = tag_of(op, l, irq);
      @(negedge clk);
      op_sel = 0; irq_take = 0;
      #1;
      check64(t, msr, model);
    end

    // mid-run reset after disturbing the value
    @(negedge clk); op_sel = 3'd2; l_field = 0; operand = 64'h0; #1;
    @(negedge clk); op_sel = 0;
    apply_reset();
    #1;
    check64("R1", msr, 64'h8000_0000_0000_0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule